// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the routing state of a set of interrupt sources and decides which of them are offered to each processor. Software reaches it over a simple 32-bit word bus. Each access also carries the index of the processor that issued it. Each source has an enable bit, a pending bit and an active bit. Each of these bits is changed only through a pair of aliases, one that sets bits and one that clears them, so that several agents can update different sources without a read-modify-write. Every source also has an 8-bit processor target mask and a trigger setting, either level or edge.

Sources 0 to 31 are private to each processor. Sources 0 to 15 are software-only and have no input line. Sources 16 to 31 take one input line per processor. Each processor sees its own copy of the enable, pending, active and trigger state for these sources. Sources from 32 upward are shared, and their hardware lines are routed by the target masks. A two-state controller, `DS_OFF` and `DS_ON`, gates all forwarding. A write to the control word with bit 0 set moves it from `DS_OFF` to `DS_ON`. A write with bit 0 clear moves it back to `DS_OFF`. Any other access leaves it in its current state. The output is one pending vector per processor, for the processor-side interfaces that sit after this block.

Top module: `irq_dist_regs`

## Requirements
- R1: Writing 1 to a bit of a set alias sets that source's enable, pending or active bit. Writing 1 to a bit of a clear alias clears it. Bits written as 0 leave the state unchanged.
- R2: The word address map (10-bit word address) is as follows. Control is at 0x000. The type word is at 0x001. The enable aliases are at 0x040 (set) and 0x060 (clear). The pending aliases are at 0x080 (set) and 0x0A0 (clear). The active aliases are at 0x0C0 (set) and 0x0E0 (clear). Within each alias, source n is bit n%32 of word base+n/32.
- R3: A read of either alias of a state bank returns the current bits for the requesting processor's view. Read data and `bus_rvalid` appear on the cycle after the request.
- R4: Target masks live at word 0x100+n/4, with source n in bits [8*(n%4)+7 : 8*(n%4)]. Masks for sources 32 and up are written and read back there.
- R5: Target words for sources 0 to 31 ignore writes. Every byte of them reads as 1 shifted left by the requesting processor index.
- R6: Enable, pending, active and trigger state of sources 0 to 31 are kept in one copy per processor. The copy is selected by `bus_cpu`. Line inputs 16 to 31 of processor k are `ppi_lines[16k+j]`.
- R7: Trigger words sit at 0x200+n/16, with bit 2*(n%16)+1 set for an edge-triggered source and clear for a level-triggered one. Even bits read 0. Sources 0 to 15 always read as edge and ignore writes.
- R8: Bits [4:0] of the type word read NUM_SRC/32-1. The other bits read 0.
- R9: In state `DS_OFF` (the reset state) every forwarding output is 0. Control writes move between `DS_OFF` and `DS_ON` according to bit 0, and control bit 0 reads the current state.
- R10: An edge-triggered source becomes pending on the clock edge that samples a rising input. It stays pending after the input falls, until a pending-clear write.
- R11: A level-triggered source is pending exactly while its input is high. When the input is low, it reads not pending unless it was set through the pending-set alias.
- R12: Output bit k*NUM_SRC+n of `cpu_fwd` is 1 when all of the following hold: the controller is in `DS_ON`, source n is pending, enabled and not active in processor k's view, and bit k of its target mask is set. Private sources always target their own processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_cpu | input | CPU_W | Index of the requesting processor |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| spi_lines | input | NUM_SRC-32 | Inputs of shared sources 32 and up |
| ppi_lines | input | NUM_CPU*16 | Private inputs of sources 16 to 31, 16 per processor |
| cpu_fwd | output | NUM_CPU*NUM_SRC | Forwarded pending vector per processor |

## Verification
The assertions assume that `bus_cpu` always names an existing processor and that `bus_req` is one cycle per access. They also assume that the input lines are synchronous to `clk`, so a rising line is seen by exactly one sampling edge. The stimulus drives every bus field and line on the falling clock edge and issues one access at a time with a gap after it. It uses only processor indices 0 and 1 of the default two-processor build, and it holds each line level for at least one full cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W = 10;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE,
        RG_EN_S, RG_EN_C, RG_PD_S, RG_PD_C, RG_AC_S, RG_AC_C,
        RG_TGT, RG_CFG
    } region_e;

    typedef enum logic {DS_OFF, DS_ON} dist_state_e;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        region_e r;
        r = RG_NONE;
        if (a == 10'h000)           r = RG_CTRL;
        else if (a == 10'h001)      r = RG_TYPE;
        else if (a[9:8] == 2'b01)   r = RG_TGT;
        else if (a[9:6] == 4'b1000) r = RG_CFG;
        else if (a[9:8] == 2'b00) begin
            case (a[7:5])
                3'd2:    r = RG_EN_S;
                3'd3:    r = RG_EN_C;
                3'd4:    r = RG_PD_S;
                3'd5:    r = RG_PD_C;
                3'd6:    r = RG_AC_S;
                3'd7:    r = RG_AC_C;
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/irqd_bank.sv
module irqd_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] set_en,
    input  logic [N-1:0] clr_en,
    input  logic [N-1:0] set_pd,
    input  logic [N-1:0] clr_pd,
    input  logic [N-1:0] set_ac,
    input  logic [N-1:0] clr_ac,
    output logic [N-1:0] enabled,
    output logic [N-1:0] pending,
    output logic [N-1:0] active
);
    logic [N-1:0] en_q, pd_q, ac_q, line_q, rise;

    assign rise = edge_mode & line & ~line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pd_q   <= '0;
            ac_q   <= '0;
            line_q <= '0;
        end else begin
            en_q   <= (en_q | set_en) & ~clr_en;
            pd_q   <= (pd_q & ~clr_pd) | set_pd | rise;
            ac_q   <= (ac_q | set_ac) & ~clr_ac;
            line_q <= line;
        end
    end

    assign enabled = en_q;
    assign pending = pd_q | (~edge_mode & line);
    assign active  = ac_q;

    // R1: a clear-alias hit leaves the bit at 0
    p_clear_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en != '0) |=> ((en_q & $past(clr_en)) == '0));
    p_clear_ac_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ac != '0) |=> ((ac_q & $past(clr_ac)) == '0));
    // R10: a sampled rising edge is captured as pending
    p_edge_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> (($past(rise) & ~pending) == '0));
endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2
) (
    input  logic                              glb_on,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]   en,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]   pd,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]   ac,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]   hit,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   fwd
);
    for (genvar k = 0; k < NUM_CPU; k++) begin : g_fwd
        assign fwd[k] = glb_on ? (en[k] & pd[k] & ~ac[k] & hit[k]) : '0;
    end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NSPI   = NUM_SRC - 32,
    localparam int WORDS  = NUM_SRC / 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_req,
    input  logic                       bus_we,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic [9:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       bus_rvalid,
    input  logic [NSPI-1:0]            spi_lines,
    input  logic [NUM_CPU*16-1:0]      ppi_lines,
    output logic [NUM_CPU*NUM_SRC-1:0] cpu_fwd
);
    region_e     rg;
    logic        wr, rd, glb_on;
    dist_state_e state_q, state_d;

    assign rg = decode_region(bus_addr);
    assign wr = bus_req & bus_we;
    assign rd = bus_req & ~bus_we;

    // ---------------- control state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_OFF: if (wr && rg == RG_CTRL &&  bus_wdata[0]) state_d = DS_ON;
            DS_ON:  if (wr && rg == RG_CTRL && !bus_wdata[0]) state_d = DS_OFF;
        endcase
    end

    always_comb begin
        glb_on = (state_q == DS_ON);
    end

    // ---------------- write strobes ----------------
    logic [NUM_SRC-1:0] w1, st_ens, st_enc, st_pds, st_pdc, st_acs, st_acc;

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++)
            w1[n] = wr && (bus_addr[4:0] == 5'(n / 32)) && bus_wdata[n % 32];
    end

    assign st_ens = (rg == RG_EN_S) ? w1 : '0;
    assign st_enc = (rg == RG_EN_C) ? w1 : '0;
    assign st_pds = (rg == RG_PD_S) ? w1 : '0;
    assign st_pdc = (rg == RG_PD_C) ? w1 : '0;
    assign st_acs = (rg == RG_AC_S) ? w1 : '0;
    assign st_acc = (rg == RG_AC_C) ? w1 : '0;

    // ---------------- target and trigger storage ----------------
    logic [NSPI-1:0][7:0]          tgt_q;
    logic [NSPI-1:0]               spi_edge_q;
    logic [NUM_CPU-1:0][15:0]      ppi_edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q      <= '0;
            spi_edge_q <= '0;
            ppi_edge_q <= '0;
        end else begin
            for (int n = 32; n < NUM_SRC; n++) begin
                if (wr && rg == RG_TGT && bus_addr[7:0] == 8'(n / 4))
                    tgt_q[n-32] <= bus_wdata[8*(n%4) +: 8];
                if (wr && rg == RG_CFG && bus_addr[5:0] == 6'(n / 16))
                    spi_edge_q[n-32] <= bus_wdata[2*(n%16)+1];
            end
            for (int k = 0; k < NUM_CPU; k++)
                for (int j = 0; j < 16; j++)
                    if (wr && rg == RG_CFG && bus_addr[5:0] == 6'd1 && bus_cpu == CPU_W'(k))
                        ppi_edge_q[k][j] <= bus_wdata[2*j+1];
        end
    end

    // ---------------- state banks ----------------
    logic [NSPI-1:0] sh_en, sh_pd, sh_ac;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] v_en, v_pd, v_ac, v_hit, fwd;

    irqd_bank #(.N(NSPI)) u_shared (
        .clk, .rst_n,
        .line(spi_lines), .edge_mode(spi_edge_q),
        .set_en(st_ens[NUM_SRC-1:32]), .clr_en(st_enc[NUM_SRC-1:32]),
        .set_pd(st_pds[NUM_SRC-1:32]), .clr_pd(st_pdc[NUM_SRC-1:32]),
        .set_ac(st_acs[NUM_SRC-1:32]), .clr_ac(st_acc[NUM_SRC-1:32]),
        .enabled(sh_en), .pending(sh_pd), .active(sh_ac)
    );

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        logic [31:0] own, b_en, b_pd, b_ac;
        assign own = {32{bus_cpu == CPU_W'(k)}};

        irqd_bank #(.N(32)) u_private (
            .clk, .rst_n,
            .line({ppi_lines[k*16 +: 16], 16'h0000}),
            .edge_mode({ppi_edge_q[k], 16'hFFFF}),
            .set_en(st_ens[31:0] & own), .clr_en(st_enc[31:0] & own),
            .set_pd(st_pds[31:0] & own), .clr_pd(st_pdc[31:0] & own),
            .set_ac(st_acs[31:0] & own), .clr_ac(st_acc[31:0] & own),
            .enabled(b_en), .pending(b_pd), .active(b_ac)
        );

        assign v_en[k] = {sh_en, b_en};
        assign v_pd[k] = {sh_pd, b_pd};
        assign v_ac[k] = {sh_ac, b_ac};

        always_comb begin
            for (int n = 0; n < NSPI; n++) v_hit[k][n+32] = tgt_q[n][k];
            v_hit[k][31:0] = '1;
        end
    end

    irqd_route #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_route (
        .glb_on, .en(v_en), .pd(v_pd), .ac(v_ac), .hit(v_hit), .fwd
    );

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_out
        assign cpu_fwd[k*NUM_SRC +: NUM_SRC] = fwd[k];
    end

    // ---------------- read path ----------------
    logic [NUM_SRC-1:0] cur_en, cur_pd, cur_ac;
    logic [15:0]        cur_edge;
    logic [7:0]         own_mask;
    logic [31:0]        rd_mux;

    assign own_mask = 8'(1) << bus_cpu;

    always_comb begin
        cur_en = '0; cur_pd = '0; cur_ac = '0; cur_edge = '0;
        for (int k = 0; k < NUM_CPU; k++)
            if (bus_cpu == CPU_W'(k)) begin
                cur_en = v_en[k]; cur_pd = v_pd[k]; cur_ac = v_ac[k];
                cur_edge = ppi_edge_q[k];
            end
        rd_mux = '0;
        case (rg)
            RG_CTRL: rd_mux[0] = glb_on;
            RG_TYPE: rd_mux[4:0] = 5'(WORDS - 1);
            RG_EN_S, RG_EN_C:
                for (int n = 0; n < NUM_SRC; n++)
                    if (bus_addr[4:0] == 5'(n / 32)) rd_mux[n%32] = cur_en[n];
            RG_PD_S, RG_PD_C:
                for (int n = 0; n < NUM_SRC; n++)
                    if (bus_addr[4:0] == 5'(n / 32)) rd_mux[n%32] = cur_pd[n];
            RG_AC_S, RG_AC_C:
                for (int n = 0; n < NUM_SRC; n++)
                    if (bus_addr[4:0] == 5'(n / 32)) rd_mux[n%32] = cur_ac[n];
            RG_TGT: begin
                if (bus_addr[7:0] < 8'd8) rd_mux = {4{own_mask}};
                for (int n = 32; n < NUM_SRC; n++)
                    if (bus_addr[7:0] == 8'(n / 4)) rd_mux[8*(n%4) +: 8] = tgt_q[n-32];
            end
            RG_CFG: begin
                if (bus_addr[5:0] == 6'd0) rd_mux = 32'hAAAA_AAAA;
                for (int j = 0; j < 16; j++)
                    if (bus_addr[5:0] == 6'd1) rd_mux[2*j+1] = cur_edge[j];
                for (int n = 32; n < NUM_SRC; n++)
                    if (bus_addr[5:0] == 6'(n / 16)) rd_mux[2*(n%16)+1] = spi_edge_q[n-32];
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd;
            if (rd) bus_rdata <= rd_mux;
        end
    end

    // R3: every read is answered on the next cycle
    p_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);
    // R8: type word reports the source count
    p_type_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rg == RG_TYPE) |=> (bus_rdata[4:0] == 5'(WORDS - 1)));
    // R9: control write selects the next state
    p_ctrl_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rg == RG_CTRL) |=> (glb_on == $past(bus_wdata[0])));
    // R9: nothing is forwarded while disabled
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_OFF) |-> (cpu_fwd == '0));
    // R5: private target words answer with the requester's own bit
    p_tgt_private_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rg == RG_TGT && bus_addr[7:0] < 8'd8) |=> (bus_rdata == {4{$past(own_mask)}}));
endmodule

// File: tb/tb_irq_dist_regs.sv
`timescale 1ns/1ps
module tb_irq_dist_regs;
    localparam int NS = 64;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NS-33:0]    spi_lines = '0;
    logic [NC*16-1:0]  ppi_lines = '0;
    logic [NC*NS-1:0]  cpu_fwd;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_dist_regs #(.NUM_SRC(NS), .NUM_CPU(NC)) dut (
        .clk, .rst_n, .bus_req, .bus_we, .bus_cpu, .bus_addr, .bus_wdata,
        .bus_rdata, .bus_rvalid, .spi_lines, .ppi_lines, .cpu_fwd
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int cpu, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_cpu = 1'(cpu); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd_reg(input int cpu, input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_cpu = 1'(cpu); bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        check("R3 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R9 reset fwd", 32'(cpu_fwd != '0), 32'd0);
        rd_reg(0, 10'h000, d); check("R9 reset ctrl", d, 32'd0);
        rd_reg(0, 10'h001, d); check("R8 type", d, 32'd1);
        rd_reg(0, 10'h041, d); check("R2 reset enable", d, 32'd0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr_reg(0, 10'h041, 32'h0000_0005);
        rd_reg(0, 10'h041, d); check("R1 enable set", d, 32'h5);
        wr_reg(0, 10'h041, 32'h0);
        rd_reg(0, 10'h041, d); check("R1 zero write", d, 32'h5);
        wr_reg(0, 10'h061, 32'h1);
        rd_reg(0, 10'h061, d); check("R3 clear alias read", d, 32'h4);
        wr_reg(0, 10'h061, 32'h4);
        wr_reg(0, 10'h081, 32'h8);
        rd_reg(0, 10'h081, d); check("R1 pending set", d, 32'h8);
        wr_reg(0, 10'h0C1, 32'h8);
        rd_reg(0, 10'h0C1, d); check("R1 active set", d, 32'h8);
        wr_reg(0, 10'h0A1, 32'h8);
        wr_reg(0, 10'h0E1, 32'h8);
        rd_reg(0, 10'h081, d); check("R1 pending clear", d, 32'h0);
        rd_reg(0, 10'h0C1, d); check("R1 active clear", d, 32'h0);
    endtask

    task automatic t_targets();
        logic [31:0] d;
        wr_reg(0, 10'h108, 32'h0201_0201);
        rd_reg(1, 10'h108, d); check("R4 target rw", d, 32'h0201_0201);
        rd_reg(1, 10'h100, d); check("R5 private target cpu1", d, 32'h0202_0202);
        wr_reg(0, 10'h103, 32'hFFFF_FFFF);
        rd_reg(0, 10'h103, d); check("R5 private target ro", d, 32'h0101_0101);
    endtask

    task automatic t_banked();
        logic [31:0] d;
        wr_reg(0, 10'h040, 32'h1);
        rd_reg(1, 10'h040, d); check("R6 other copy", d, 32'h0);
        rd_reg(0, 10'h040, d); check("R6 own copy", d, 32'h1);
        wr_reg(0, 10'h060, 32'h1);
    endtask

    task automatic t_config();
        logic [31:0] d;
        wr_reg(0, 10'h202, 32'h0000_0002);
        rd_reg(0, 10'h202, d); check("R7 shared trigger", d, 32'h2);
        wr_reg(0, 10'h200, 32'h0);
        rd_reg(0, 10'h200, d); check("R7 software sources fixed", d, 32'hAAAA_AAAA);
        wr_reg(0, 10'h201, 32'hFFFF_FFFF);
        rd_reg(0, 10'h201, d); check("R7 private trigger", d, 32'hAAAA_AAAA);
        rd_reg(1, 10'h201, d); check("R6 private trigger copy", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr_reg(0, 10'h108, 32'h0000_0102);
        wr_reg(0, 10'h041, 32'h3);
        wr_reg(0, 10'h000, 32'h1);
        rd_reg(0, 10'h000, d); check("R9 ctrl on", d, 32'h1);
        spi_lines[0] = 1'b1;
        @(negedge clk);
        check("R12 target cpu1", 32'(cpu_fwd[NS+32]), 32'd1);
        check("R12 not cpu0", 32'(cpu_fwd[32]), 32'd0);
        spi_lines[0] = 1'b0;
        @(negedge clk);
        check("R10 edge held", 32'(cpu_fwd[NS+32]), 32'd1);
        rd_reg(0, 10'h081, d); check("R10 pending read", d & 32'h1, 32'h1);
        wr_reg(0, 10'h0C1, 32'h1);
        check("R12 active blocks", 32'(cpu_fwd[NS+32]), 32'd0);
        wr_reg(0, 10'h0E1, 32'h1);
        check("R12 inactive forwards", 32'(cpu_fwd[NS+32]), 32'd1);
        wr_reg(0, 10'h000, 32'h0);
        check("R9 off gates", 32'(cpu_fwd != '0), 32'd0);
        wr_reg(0, 10'h000, 32'h1);
        check("R9 on again", 32'(cpu_fwd[NS+32]), 32'd1);
        wr_reg(0, 10'h0A1, 32'h1);
        check("R10 cleared", 32'(cpu_fwd[NS+32]), 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        spi_lines[1] = 1'b1;
        @(negedge clk);
        check("R11 level high", 32'(cpu_fwd[33]), 32'd1);
        check("R12 level not cpu1", 32'(cpu_fwd[NS+33]), 32'd0);
        spi_lines[1] = 1'b0;
        @(negedge clk);
        check("R11 level low", 32'(cpu_fwd[33]), 32'd0);
        rd_reg(0, 10'h081, d); check("R11 no latch", d & 32'h2, 32'h0);
    endtask

    task automatic t_private_line();
        wr_reg(1, 10'h040, 32'h0001_0000);
        ppi_lines[16] = 1'b1;
        ppi_lines[0]  = 1'b1;
        @(negedge clk);
        check("R6 cpu1 private line", 32'(cpu_fwd[NS+16]), 32'd1);
        check("R6 cpu0 not enabled", 32'(cpu_fwd[16]), 32'd0);
        ppi_lines = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_targets();
        t_banked();
        t_config();
        t_route();
        t_level();
        t_private_line();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule